// File: doc/BRIEF.md
# Segmented Approximate Binary Adder

This block adds two unsigned operands of `WIDTH` bits and returns a `WIDTH+1`-bit result in which only the upper part is exact. The lowest `APPROX_BITS` positions are cut into 2-bit slices. Each slice adds its own two operand bit pairs exactly, with a carry-in of zero. Any carry a slice produces is dropped. No carry passes from one slice to the next, and none passes from the slices into the upper part. Each slice therefore depends on only four input bits, which keeps the low part shallow and narrow. The upper `WIDTH-APPROX_BITS` bits form an ordinary exact adder, and its carry-out is the top bit of the result.

The block is meant for datapaths that tolerate small errors, such as filters and accumulators for media or learning workloads. In those datapaths, a short carry chain matters more than the last few bits of precision. A parameter selects whether the result is registered, which adds one cycle of latency and a synchronous active-high clear, or driven straight from the adder logic. The default configuration is a 32-bit adder with eight approximate bits, which gives four slices. With `APPROX_BITS` set to zero, the block is an exact adder. An odd `APPROX_BITS`, or one larger than `WIDTH`, stops elaboration.

Top module: `seg_approx_adder`

## Requirements
- R1: Result bits `WIDTH:APPROX_BITS` equal the exact sum of operand bits `WIDTH-1:APPROX_BITS` with a carry-in of zero. The top result bit is the carry-out of that sum.
- R2: For each slice i below `APPROX_BITS/2`, result bits `2i+1:2i` equal `(opA[2i+1:2i] + opB[2i+1:2i]) mod 4`.
- R3: A carry produced by a slice is discarded. It changes neither the next slice nor the exact upper part. For example, low bytes 0xC0 + 0x40 give 0x00 in bits 7:0, with nothing added at bit 8.
- R4: With `APPROX_BITS = 0`, the result equals `opA + opB` exactly for every operand pair.
- R5: With `REGISTERED = 1`, the result presented after a rising clock edge belongs to the operands sampled at that edge. Until the next edge, it does not follow changes on the operands.
- R6: With `REGISTERED = 1`, a clock edge that sees `rst` high sets the result to zero, whatever the operands are.
- R7: The two sum bits of a slice depend only on that slice's four operand bits. Any setting of the other operand bits leaves them unchanged.
- R8: The result never exceeds the exact sum. The shortfall is at most the sum of `2^(2i+2)` over all slices, which is 340 for the default configuration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high clear of the output register |
| opA | input | WIDTH | First unsigned operand |
| opB | input | WIDTH | Second unsigned operand |
| sum | output | WIDTH+1 | Approximate sum |

## Verification
On every cycle, the assertions compare the result against the operands that produced it. They check the exact upper field and each wrapped 2-bit slice. They also check that the result never exceeds the exact sum and that the shortfall stays within its bound, and that the output reads zero right after a clear. The bench's scenarios show several things the per-cycle checks cannot. The operand values chosen to force a slice carry show that the carry vanishes. Holding one slice's bits fixed while the other bits vary shows that the slice is isolated. A second instance built with no approximate bits shows that the block becomes exact. Changing the operands between clock edges shows the one-cycle latency. Over a long random run, the bench measures the mean error distance against exact addition and reports it.

// File: rtl/seg_adder_pkg.sv
package seg_adder_pkg;
  typedef struct packed {
    logic capture;
    logic clear;
  } stage_ctrl_t;

  function automatic int unsigned maxShortfall(input int unsigned approxBits);
    int unsigned acc;
    acc = 0;
    for (int i = 0; i < int'(approxBits / 2); i++) begin
      acc += (32'd1 << (2 * i + 2));
    end
    return acc;
  endfunction
endpackage

// File: rtl/seg_adder_low.sv
module seg_adder_low #(
  parameter int LOW_BITS = 8
) (
  input  logic [LOW_BITS-1:0] lowA,
  input  logic [LOW_BITS-1:0] lowB,
  output logic [LOW_BITS-1:0] lowSum
);
  localparam int SLICES = LOW_BITS / 2;

  for (genvar s = 0; s < SLICES; s++) begin : g_slice
    logic [1:0] pairA;
    logic [1:0] pairB;
    assign pairA = lowA[2*s +: 2];
    assign pairB = lowB[2*s +: 2];
    // 2-bit result: the slice carry falls off the top
    assign lowSum[2*s +: 2] = pairA + pairB;
  end
endmodule

// File: rtl/seg_adder_high.sv
module seg_adder_high #(
  parameter int HI_BITS = 24
) (
  input  logic [HI_BITS-1:0] hiA,
  input  logic [HI_BITS-1:0] hiB,
  output logic [HI_BITS:0]   hiSum
);
  assign hiSum = {1'b0, hiA} + {1'b0, hiB};
endmodule

// File: rtl/seg_adder_ctrl.sv
module seg_adder_ctrl
  import seg_adder_pkg::*;
(
  input  logic        rst,
  output stage_ctrl_t stageCtrl
);
  always_comb begin
    stageCtrl.clear   = rst;
    stageCtrl.capture = !rst;
  end
endmodule

// File: rtl/seg_adder_dp.sv
module seg_adder_dp
  import seg_adder_pkg::*;
#(
  parameter int WIDTH       = 32,
  parameter int APPROX_BITS = 8,
  parameter bit REGISTERED  = 1'b1
) (
  input  logic              clk,
  input  stage_ctrl_t       stageCtrl,
  input  logic [WIDTH-1:0]  opA,
  input  logic [WIDTH-1:0]  opB,
  output logic [WIDTH:0]    sum
);
  localparam int HI_BITS = WIDTH - APPROX_BITS;

  logic [WIDTH:0] rawSum;

  if (APPROX_BITS > 0) begin : g_low
    logic [APPROX_BITS-1:0] lowSum;
    seg_adder_low #(.LOW_BITS(APPROX_BITS)) u_low (
      .lowA  (opA[APPROX_BITS-1:0]),
      .lowB  (opB[APPROX_BITS-1:0]),
      .lowSum(lowSum)
    );
    assign rawSum[APPROX_BITS-1:0] = lowSum;
  end

  if (HI_BITS > 0) begin : g_high
    logic [HI_BITS:0] hiSum;
    seg_adder_high #(.HI_BITS(HI_BITS)) u_high (
      .hiA  (opA[WIDTH-1:APPROX_BITS]),
      .hiB  (opB[WIDTH-1:APPROX_BITS]),
      .hiSum(hiSum)
    );
    assign rawSum[WIDTH:APPROX_BITS] = hiSum;
  end else begin : g_no_high
    assign rawSum[WIDTH] = 1'b0;
  end

  if (REGISTERED) begin : g_reg
    logic [WIDTH:0] sumQ;
    always_ff @(posedge clk) begin
      if (stageCtrl.clear)        sumQ <= '0;
      else if (stageCtrl.capture) sumQ <= rawSum;
    end
    assign sum = sumQ;
  end else begin : g_comb
    assign sum = rawSum;
  end
endmodule

// File: rtl/seg_approx_adder.sv
module seg_approx_adder
  import seg_adder_pkg::*;
#(
  parameter int WIDTH       = 32,
  parameter int APPROX_BITS = 8,
  parameter bit REGISTERED  = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH:0]   sum
);
  if ((APPROX_BITS % 2) != 0 || APPROX_BITS < 0 || APPROX_BITS > WIDTH || WIDTH < 1) begin : g_bad_params
    $error("seg_approx_adder: APPROX_BITS must be even and within 0..WIDTH");
  end

  stage_ctrl_t stageCtrl;

  seg_adder_ctrl u_ctrl (
    .rst      (rst),
    .stageCtrl(stageCtrl)
  );

  seg_adder_dp #(
    .WIDTH      (WIDTH),
    .APPROX_BITS(APPROX_BITS),
    .REGISTERED (REGISTERED)
  ) u_dp (
    .clk      (clk),
    .stageCtrl(stageCtrl),
    .opA      (opA),
    .opB      (opB),
    .sum      (sum)
  );
endmodule

// File: rtl/seg_adder_checker.sv
module seg_adder_checker
  import seg_adder_pkg::*;
#(
  parameter int WIDTH       = 32,
  parameter int APPROX_BITS = 8,
  parameter bit REGISTERED  = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic [WIDTH:0]   sum
);
  localparam logic [WIDTH:0] ERR_MAX = (WIDTH+1)'(maxShortfall(APPROX_BITS));

  logic [WIDTH-1:0] capA, capB, refA, refB;
  logic primed, wasRst;
  logic [WIDTH:0] exact;

  always_ff @(posedge clk) begin
    capA   <= opA;
    capB   <= opB;
    wasRst <= rst;
    primed <= !rst;
  end

  assign refA  = REGISTERED ? capA : opA;
  assign refB  = REGISTERED ? capB : opB;
  assign exact = {1'b0, refA} + {1'b0, refB};

  AST_NOT_ABOVE_EXACT: assert property (@(posedge clk) disable iff (rst)
    primed |-> sum <= exact); // R8
  AST_ERROR_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    primed |-> (exact - sum) <= ERR_MAX); // R8

  if (APPROX_BITS < WIDTH) begin : g_hi_chk
    AST_HIGH_EXACT: assert property (@(posedge clk) disable iff (rst)
      primed |-> sum[WIDTH:APPROX_BITS] ==
        ({1'b0, refA[WIDTH-1:APPROX_BITS]} + {1'b0, refB[WIDTH-1:APPROX_BITS]})); // R1
  end

  for (genvar s = 0; s < APPROX_BITS / 2; s++) begin : g_slice_chk
    AST_SLICE_WRAP: assert property (@(posedge clk) disable iff (rst)
      primed |-> sum[2*s +: 2] == 2'(refA[2*s +: 2] + refB[2*s +: 2])); // R2
  end

  if (REGISTERED) begin : g_rst_chk
    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
      wasRst |-> sum == '0); // R6
  end
endmodule

bind seg_approx_adder seg_adder_checker #(
  .WIDTH      (WIDTH),
  .APPROX_BITS(APPROX_BITS),
  .REGISTERED (REGISTERED)
) u_checker (
  .clk(clk),
  .rst(rst),
  .opA(opA),
  .opB(opB),
  .sum(sum)
);

// File: tb/test_seg_approx_adder.sv
module test_seg_approx_adder;
  localparam int W = 32;
  localparam int K = 8;
  localparam longint unsigned ERR_MAX = 340;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst;
  logic [W-1:0] a, b;
  logic [W:0]   sumAp, sumEx;

  seg_approx_adder #(.WIDTH(W), .APPROX_BITS(K), .REGISTERED(1'b1)) i_seg_approx_adder (
    .clk(clk), .rst(rst), .opA(a), .opB(b), .sum(sumAp)
  );

  seg_approx_adder #(.WIDTH(W), .APPROX_BITS(0), .REGISTERED(1'b0)) i_seg_approx_adder_exact (
    .clk(clk), .rst(rst), .opA(a), .opB(b), .sum(sumEx)
  );

  typedef struct {
    logic [W:0] expSum;
    logic [W:0] exact;
    string      tag;
  } item_t;

  item_t sbq[$];
  int checks = 0;
  int fails  = 0;
  longint unsigned errTotal = 0;
  int errCount = 0;
  bit done = 0;

  function automatic logic [W:0] model(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W:0] r;
    r = ({1'b0, x[W-1:K]} + {1'b0, y[W-1:K]}) << K;
    for (int i = 0; i < K / 2; i++) r[2*i +: 2] = 2'(x[2*i +: 2] + y[2*i +: 2]);
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [W:0] act, input logic [W:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: apply on falling edge, queue expectation, check exact instance
  task automatic drive(input logic [W-1:0] x, input logic [W-1:0] y, input string tag);
    item_t it;
    @(negedge clk);
    a = x;
    b = y;
    it.expSum = model(x, y);
    it.exact  = {1'b0, x} + {1'b0, y};
    it.tag    = tag;
    sbq.push_back(it);
    #1;
    check(sumEx == it.exact, "R4", sumEx, it.exact);
  endtask

  // monitor: after each rising edge, compare against the queued item
  always @(posedge clk) begin
    #2;
    if (!rst && sbq.size() > 0) begin
      item_t it;
      longint unsigned diff;
      it = sbq.pop_front();
      check(sumAp == it.expSum, it.tag, sumAp, it.expSum);
      diff = longint'(it.exact) - longint'(sumAp);
      check(sumAp <= it.exact && diff <= ERR_MAX, "R8", sumAp, it.exact);
      errTotal += diff;
      errCount++;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    a = '0;
    b = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(sumAp == '0, "R6", sumAp, '0);
    rst = 1'b0;

    drive(32'h0, 32'h0, "R1");
    drive(32'h0000_00C0, 32'h0000_0040, "R3");
    drive(32'h0000_00FF, 32'h0000_0001, "R3");
    drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R1");
    drive(32'h8000_0000, 32'h8000_0000, "R1");
    drive(32'h0000_0102, 32'h0000_0203, "R2");
    drive(32'h1234_5655, 32'h0FED_CBAA, "R2");
    // slice isolation: bits 3:2 held at 2+3, all other bits varied
    drive(32'h0000_0008, 32'h0000_000C, "R7");
    drive(32'hFFFF_FFFB, 32'hA5A5_A5AF, "R7");
    drive(32'h0F0F_0F38, 32'hF0F0_F0CD, "R7");

    // latency: output holds previous result until next edge
    drive(32'd5, 32'd6, "R5");
    @(negedge clk);
    a = 32'd100;
    b = 32'd200;
    #1;
    check(sumAp == model(32'd5, 32'd6), "R5", sumAp, model(32'd5, 32'd6));
    begin
      item_t it;
      it.expSum = model(32'd100, 32'd200);
      it.exact  = 33'd300;
      it.tag    = "R5";
      sbq.push_back(it);
    end

    for (int n = 0; n < 4000; n++) drive($urandom, $urandom, "R2");

    // mid-run clear with non-zero operands
    @(negedge clk);
    wait (sbq.size() == 0);
    rst = 1'b1;
    a = 32'hFFFF_FFFF;
    b = 32'h1357_9BDF;
    @(negedge clk);
    check(sumAp == '0, "R6", sumAp, '0);
    rst = 1'b0;
    drive(32'h0000_0003, 32'h0000_0001, "R3");
    repeat (3) @(negedge clk);

    if (errCount > 0)
      $display("mean error distance = %f over %0d vectors",
               real'(errTotal) / real'(errCount), errCount);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule